// File: doc/BRIEF.md
# Permission-Checked Set-Associative Tag Directory

This block is the tag side of a set-associative cache controller. Each way of each set holds a line address, a two-bit coherence permission and a lock-owner context. A controller sends one command per cycle on a valid/ready port: it can look a line up, check whether a request type may use the line, allocate or free a way, set the permission, ask which line would be evicted, or set, clear and test a lock reservation. Every accepted command gets its result one cycle later.

The permission decides what counts as a hit. A line marked not-present still holds its tag but behaves as a free way. A lookup hits on any other state. An access check hits only when the permission allows the request type. A per-set least-recently-used order picks the victim. Lookups and access checks that find their line move it to most recent, even when the permission check then fails. Allocations do the same. Data storage and protocol actions are left to the surrounding controller.

Addresses at the port are line addresses, with the byte offset already removed. The set index is the field of `SET_W` bits that starts at bit `IDX_LSB` of the line address. `SET_W` is log2 of CACHE_BYTES / WAYS / LINE_BYTES. With the default parameters this gives 8 sets of 4 ways, and the index is taken from line bits [2:0].

Top module: `perm_tag_dir`

## Requirements
- R1: `cmd_ready` is always 1. A command accepted at a clock edge gives `rsp_valid`=1 with its results after that edge, and after a cycle with no command `rsp_valid` is 0.
- R2: The set is `cmd_line[IDX_LSB +: SET_W]`. Lines that differ only in the other bits share a set, and a command on one set never changes another set.
- R3: Permission codes are 0 not-present, 1 invalid, 2 read-only and 3 read-write. The line is present when a filled way holds the same line address and its permission is not 0. For every opcode except access check (1) and lock test (7), `rsp_hit` is 1 exactly when the line is present. `rsp_way` and `rsp_perm` then give that way and its permission; otherwise `rsp_perm` is 0.
- R4: The access check (opcode 1) hits when the line is present and either the permission is 3, or the permission is 2 and `cmd_req` is load (0) or instruction fetch (1). A store (2) to a read-only line fails, and any request to an invalid line fails.
- R5: `rsp_avail` is 1 when the line is present in the set, or when any way of the set is empty or not-present.
- R6: Allocate (opcode 2) fills the lowest-numbered way that is empty or not-present. It stores the line with permission 1 and lock value all-ones, reports that way in `rsp_way`, and makes the way most recently used.
- R7: Allocating a line that is already present, or allocating into a set with no free way, sets `rsp_err` and leaves the directory and the LRU order unchanged.
- R8: Deallocate (opcode 3) empties the way that holds a present line. On an absent line it sets `rsp_err` and changes nothing.
- R9: When `rsp_avail` is 0, `rsp_victim` holds the line of the least recently used way; otherwise it is 0. After reset way 0 is the first victim, then ways 1, 2 and 3 in turn. Lookups (opcode 0) and access checks that find their line, including failed checks, and successful allocations move that way to most recent. Probe (opcode 4) changes nothing.
- R10: Lock set (opcode 5) stores `cmd_ctx` as the owner and lock clear (opcode 6) stores all-ones. Lock test (opcode 7) hits only when the line is present and its owner equals `cmd_ctx`.
- R11: Set permission (opcode 8) writes `cmd_perm` into a present line. Lock set, clear or test, or set permission, on an absent line sets `rsp_err` and has no effect.
- R12: After reset every way is empty, so every lookup misses and every set has room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted (constant 1) |
| cmd_op | input | 4 | Opcode, 0 to 8 |
| cmd_line | input | LINE_W | Line address |
| cmd_req | input | 2 | Request type for access checks |
| cmd_perm | input | 2 | Permission for set-permission |
| cmd_ctx | input | CTX_W | Context for lock commands |
| rsp_valid | output | 1 | Result present |
| rsp_hit | output | 1 | Hit as defined per opcode |
| rsp_way | output | WAY_W | Way found or allocated |
| rsp_perm | output | 2 | Permission of the present line |
| rsp_avail | output | 1 | Set can take the line |
| rsp_victim | output | LINE_W | Victim line when the set is full |
| rsp_err | output | 1 | Command not allowed for this state |

## Verification
The bench focuses on the LRU order under mixed traffic. A failed store check must still move its way to most recent. A tracker that skipped that touch would name the wrong victim on the next probe. Rejected allocations and probes must leave the order alone. The bench also turns a line not-present and then allocates the same address again. A design that counted the stale tag as present would reject that allocation. A design that skipped the stale way would fill a higher way than the lowest free one. Read-only lines are checked with each request type, so granting stores or refusing instruction fetches shows up. Lock tests are run with matching and non-matching contexts and on absent lines.

// File: rtl/ptd_pkg.sv
package ptd_pkg;

  typedef enum logic [3:0] {
    OP_LOOKUP    = 4'd0,
    OP_CHECK     = 4'd1,
    OP_ALLOC     = 4'd2,
    OP_DEALLOC   = 4'd3,
    OP_PROBE     = 4'd4,
    OP_LOCK_SET  = 4'd5,
    OP_LOCK_CLR  = 4'd6,
    OP_LOCK_TEST = 4'd7,
    OP_SET_PERM  = 4'd8
  } op_e;

  localparam logic [1:0] PERM_NP  = 2'd0;
  localparam logic [1:0] PERM_INV = 2'd1;
  localparam logic [1:0] PERM_RO  = 2'd2;
  localparam logic [1:0] PERM_RW  = 2'd3;

  localparam logic [1:0] REQ_LOAD   = 2'd0;
  localparam logic [1:0] REQ_IFETCH = 2'd1;
  localparam logic [1:0] REQ_STORE  = 2'd2;

  // Read-write grants everything; read-only grants reads only.
  function automatic logic access_ok(logic [1:0] perm, logic [1:0] req);
    return (perm == PERM_RW) ||
           ((perm == PERM_RO) && ((req == REQ_LOAD) || (req == REQ_IFETCH)));
  endfunction

endpackage

// File: rtl/ptd_way_match.sv
module ptd_way_match
  import ptd_pkg::*;
#(
  parameter int WAYS   = 4,
  parameter int WAY_W  = 2,
  parameter int LINE_W = 26
) (
  input  logic [WAYS-1:0]             way_valid,
  input  logic [WAYS-1:0][1:0]        way_perm,
  input  logic [WAYS-1:0][LINE_W-1:0] way_line,
  input  logic [LINE_W-1:0]           line,
  output logic [WAYS-1:0]             hit_vec,
  output logic                        present,
  output logic [WAY_W-1:0]            present_way,
  output logic                        free,
  output logic [WAY_W-1:0]            free_way
);

  logic [WAYS-1:0] free_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit_vec[w]  = way_valid[w] && (way_line[w] == line) && (way_perm[w] != PERM_NP);
    assign free_vec[w] = !way_valid[w] || (way_perm[w] == PERM_NP);
  end

  // Lowest-numbered way wins in both encoders.
  always_comb begin
    present     = |hit_vec;
    free        = |free_vec;
    present_way = '0;
    free_way    = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w])  present_way = WAY_W'(w);
      if (free_vec[w]) free_way    = WAY_W'(w);
    end
  end

endmodule

// File: rtl/ptd_lru.sv
module ptd_lru #(
  parameter int SETS  = 8,
  parameter int WAYS  = 4,
  parameter int SET_W = 3,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set_i,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] victim_way
);

  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  // Age 0 is most recent; the ages of a set form a permutation.
  logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];
  logic [WAYS-1:0][WAY_W-1:0] cur_age;
  logic [WAYS-1:0][WAY_W-1:0] nxt_age;
  logic [WAYS-1:0]            oldest_vec;

  always_comb cur_age = age_q[set_i];

  for (genvar w = 0; w < WAYS; w++) begin : g_old
    assign oldest_vec[w] = (cur_age[w] == OLDEST);
  end

  always_comb begin
    victim_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (oldest_vec[w]) victim_way = WAY_W'(w);
    end
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      if (WAY_W'(w) == touch_way)              nxt_age[w] = '0;
      else if (cur_age[w] < cur_age[touch_way]) nxt_age[w] = cur_age[w] + 1'b1;
      else                                      nxt_age[w] = cur_age[w];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          age_q[s][w] <= WAY_W'(WAYS - 1 - w);
        end
      end
    end else if (touch_en) begin
      age_q[set_i] <= nxt_age;
    end
  end

  // R9
  lru_single_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1);

endmodule

// File: rtl/perm_tag_dir.sv
module perm_tag_dir
  import ptd_pkg::*;
#(
  parameter int LINE_W      = 26,
  parameter int LINE_BYTES  = 64,
  parameter int CACHE_BYTES = 2048,
  parameter int WAYS        = 4,
  parameter int CTX_W       = 4,
  parameter int IDX_LSB     = 0,
  localparam int SETS       = CACHE_BYTES / WAYS / LINE_BYTES,
  localparam int SET_W      = $clog2(SETS),
  localparam int WAY_W      = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [3:0]        cmd_op,
  input  logic [LINE_W-1:0] cmd_line,
  input  logic [1:0]        cmd_req,
  input  logic [1:0]        cmd_perm,
  input  logic [CTX_W-1:0]  cmd_ctx,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic [1:0]        rsp_perm,
  output logic              rsp_avail,
  output logic [LINE_W-1:0] rsp_victim,
  output logic              rsp_err
);

  localparam logic [CTX_W-1:0] UNOWNED = '1;

  // Directory state
  logic [WAYS-1:0]              valid_q [SETS];
  logic [WAYS-1:0][LINE_W-1:0]  line_q  [SETS];
  logic [WAYS-1:0][1:0]         perm_q  [SETS];
  logic [WAYS-1:0][CTX_W-1:0]   lock_q  [SETS];

  op_e                op;
  logic               accept;
  logic [SET_W-1:0]   set_idx;
  logic [WAYS-1:0]    hit_vec;
  logic               present, free, avail, alloc_ok;
  logic [WAY_W-1:0]   present_way, free_way, victim_way;
  logic [1:0]         cur_perm;
  logic [CTX_W-1:0]   cur_lock;

  logic               wr_en, wr_valid;
  logic [WAY_W-1:0]   wr_way;
  logic [LINE_W-1:0]  wr_line;
  logic [1:0]         wr_perm;
  logic [CTX_W-1:0]   wr_lock;
  logic               touch_en;
  logic [WAY_W-1:0]   touch_way;

  logic               hit_d, err_d;
  logic [WAY_W-1:0]   way_d;
  logic [1:0]         perm_d;
  logic [LINE_W-1:0]  victim_d;

  // Registered copies used by the checks
  op_e                op_q;
  logic [1:0]         req_q;
  logic [SET_W-1:0]   set_q;

  assign cmd_ready = 1'b1;
  assign accept    = cmd_valid;
  assign op        = op_e'(cmd_op);
  assign set_idx   = cmd_line[IDX_LSB +: SET_W];

  ptd_way_match #(.WAYS(WAYS), .WAY_W(WAY_W), .LINE_W(LINE_W)) u_match (
    .way_valid   (valid_q[set_idx]),
    .way_perm    (perm_q[set_idx]),
    .way_line    (line_q[set_idx]),
    .line        (cmd_line),
    .hit_vec     (hit_vec),
    .present     (present),
    .present_way (present_way),
    .free        (free),
    .free_way    (free_way)
  );

  ptd_lru #(.SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (set_idx),
    .touch_en   (touch_en),
    .touch_way  (touch_way),
    .victim_way (victim_way)
  );

  assign cur_perm = perm_q[set_idx][present_way];
  assign cur_lock = lock_q[set_idx][present_way];
  assign avail    = present || free;
  assign alloc_ok = (op == OP_ALLOC) && !present && free;

  // Next-state decision for the single way a command may write.
  always_comb begin
    wr_en     = 1'b0;
    wr_way    = present_way;
    wr_valid  = valid_q[set_idx][present_way];
    wr_line   = line_q[set_idx][present_way];
    wr_perm   = cur_perm;
    wr_lock   = cur_lock;
    touch_en  = 1'b0;
    touch_way = present_way;
    err_d     = 1'b0;
    hit_d     = present;
    unique case (op)
      OP_LOOKUP: touch_en = accept && present;
      OP_CHECK: begin
        touch_en = accept && present;
        hit_d    = present && access_ok(cur_perm, cmd_req);
      end
      OP_ALLOC: begin
        err_d = !alloc_ok;
        if (alloc_ok) begin
          wr_en     = accept;
          wr_way    = free_way;
          wr_valid  = 1'b1;
          wr_line   = cmd_line;
          wr_perm   = PERM_INV;
          wr_lock   = UNOWNED;
          touch_en  = accept;
          touch_way = free_way;
        end
      end
      OP_DEALLOC: begin
        err_d    = !present;
        wr_en    = accept && present;
        wr_valid = 1'b0;
        wr_line  = '0;
        wr_perm  = PERM_NP;
        wr_lock  = UNOWNED;
      end
      OP_LOCK_SET: begin
        err_d   = !present;
        wr_en   = accept && present;
        wr_lock = cmd_ctx;
      end
      OP_LOCK_CLR: begin
        err_d   = !present;
        wr_en   = accept && present;
        wr_lock = UNOWNED;
      end
      OP_LOCK_TEST: begin
        err_d = !present;
        hit_d = present && (cur_lock == cmd_ctx);
      end
      OP_SET_PERM: begin
        err_d   = !present;
        wr_en   = accept && present;
        wr_perm = cmd_perm;
      end
      default: ;
    endcase
    way_d    = present ? present_way : (alloc_ok ? free_way : '0);
    perm_d   = present ? cur_perm : PERM_NP;
    victim_d = avail ? '0 : line_q[set_idx][victim_way];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        line_q[s]  <= '0;
        perm_q[s]  <= '0;
        lock_q[s]  <= '1;
      end
    end else if (wr_en) begin
      valid_q[set_idx][wr_way] <= wr_valid;
      line_q[set_idx][wr_way]  <= wr_line;
      perm_q[set_idx][wr_way]  <= wr_perm;
      lock_q[set_idx][wr_way]  <= wr_lock;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_way    <= '0;
      rsp_perm   <= '0;
      rsp_avail  <= 1'b0;
      rsp_victim <= '0;
      rsp_err    <= 1'b0;
      op_q       <= OP_LOOKUP;
      req_q      <= '0;
      set_q      <= '0;
    end else begin
      rsp_valid <= accept;
      if (accept) begin
        rsp_hit    <= hit_d;
        rsp_way    <= way_d;
        rsp_perm   <= perm_d;
        rsp_avail  <= avail;
        rsp_victim <= victim_d;
        rsp_err    <= err_d;
        op_q       <= op;
        req_q      <= cmd_req;
        set_q      <= set_idx;
      end
    end
  end

  // R1
  rsp_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid);
  // R1
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_valid);
  // R7
  single_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $onehot0(hit_vec));
  // R4
  store_needs_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && op_q == OP_CHECK && req_q == REQ_STORE && rsp_hit) |-> (rsp_perm == PERM_RW));
  // R9
  victim_same_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && op_q == OP_PROBE && !rsp_avail) |-> (rsp_victim[IDX_LSB +: SET_W] == set_q));
  // R10
  lock_test_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && op_q == OP_LOCK_TEST && rsp_hit) |-> !rsp_err);

endmodule

// File: tb/perm_tag_dir_tb.sv
`timescale 1ns/1ps
module perm_tag_dir_tb;

  localparam int LW = 26, WAYS = 4, SETS = 8, CW = 4, WW = 2;

  logic          clk, rst_n;
  logic          cmd_valid, cmd_ready;
  logic [3:0]    cmd_op;
  logic [LW-1:0] cmd_line;
  logic [1:0]    cmd_req, cmd_perm;
  logic [CW-1:0] cmd_ctx;
  logic          rsp_valid, rsp_hit, rsp_avail, rsp_err;
  logic [WW-1:0] rsp_way;
  logic [1:0]    rsp_perm;
  logic [LW-1:0] rsp_victim;

  perm_tag_dir u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_line(cmd_line), .cmd_req(cmd_req), .cmd_perm(cmd_perm),
    .cmd_ctx(cmd_ctx), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
    .rsp_perm(rsp_perm), .rsp_avail(rsp_avail), .rsp_victim(rsp_victim), .rsp_err(rsp_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // Reference model: per-way fields and an MRU-first queue per set.
  int mv [SETS][WAYS];
  int mt [SETS][WAYS];
  int mp [SETS][WAYS];
  int ml [SETS][WAYS];
  int lru [SETS][$];

  logic  pend_v = 1'b0;
  int    e_hit, e_way, e_perm, e_avail, e_victim, e_err;
  string e_tag;

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < SETS; s++) begin
      lru[s].delete();
      for (int w = 0; w < WAYS; w++) begin
        mv[s][w] = 0; mt[s][w] = 0; mp[s][w] = 0; ml[s][w] = 15;
        lru[s].push_front(w);
      end
    end
  endtask

  task automatic touch(input int s, input int w);
    for (int i = 0; i < lru[s].size(); i++) begin
      if (lru[s][i] == w) begin
        lru[s].delete(i);
        break;
      end
    end
    lru[s].push_front(w);
  endtask

  task automatic compare();
    chk("R1", "cmd_ready", cmd_ready, 1);
    if (pend_v) begin
      chk("R1", "rsp_valid", rsp_valid, 1);
      chk(e_tag, "rsp_hit", rsp_hit, e_hit);
      chk(e_tag, "rsp_way", rsp_way, e_way);
      chk(e_tag, "rsp_perm", rsp_perm, e_perm);
      chk(e_tag, "rsp_avail", rsp_avail, e_avail);
      chk(e_tag, "rsp_victim", rsp_victim, e_victim);
      chk(e_tag, "rsp_err", rsp_err, e_err);
    end else begin
      chk("R1", "rsp_valid idle", rsp_valid, 0);
    end
  endtask

  // Line address = tag above the 3 set bits.
  task automatic issue(input int op, input int s, input int t, input int rq,
                       input int pm, input int cx, input string tg);
    int pw, fw, vw;
    @(negedge clk);
    compare();
    cmd_valid = 1'b1;
    cmd_op    = 4'(op);
    cmd_line  = LW'((t << 3) | s);
    cmd_req   = 2'(rq);
    cmd_perm  = 2'(pm);
    cmd_ctx   = CW'(cx);
    pw = -1; fw = -1;
    for (int w = 0; w < WAYS; w++) begin
      if (pw < 0 && mv[s][w] != 0 && mt[s][w] == t && mp[s][w] != 0) pw = w;
      if (fw < 0 && (mv[s][w] == 0 || mp[s][w] == 0)) fw = w;
    end
    vw       = lru[s][$];
    e_tag    = tg;
    e_avail  = (pw >= 0 || fw >= 0) ? 1 : 0;
    e_victim = e_avail != 0 ? 0 : ((mt[s][vw] << 3) | s);
    e_hit    = pw >= 0 ? 1 : 0;
    e_way    = pw >= 0 ? pw : 0;
    e_perm   = pw >= 0 ? mp[s][pw] : 0;
    e_err    = 0;
    case (op)
      0: if (pw >= 0) touch(s, pw);
      1: begin
        e_hit = (pw >= 0 && (mp[s][pw] == 3 || (mp[s][pw] == 2 && rq <= 1))) ? 1 : 0;
        if (pw >= 0) touch(s, pw);
      end
      2: begin
        if (pw < 0 && fw >= 0) begin
          e_way = fw;
          mv[s][fw] = 1; mt[s][fw] = t; mp[s][fw] = 1; ml[s][fw] = 15;
          touch(s, fw);
        end else e_err = 1;
      end
      3: if (pw >= 0) begin
           mv[s][pw] = 0; mt[s][pw] = 0; mp[s][pw] = 0; ml[s][pw] = 15;
         end else e_err = 1;
      5: if (pw >= 0) ml[s][pw] = cx; else e_err = 1;
      6: if (pw >= 0) ml[s][pw] = 15; else e_err = 1;
      7: begin
        e_hit = (pw >= 0 && ml[s][pw] == cx) ? 1 : 0;
        e_err = pw < 0 ? 1 : 0;
      end
      8: if (pw >= 0) mp[s][pw] = pm; else e_err = 1;
      default: ;
    endcase
    pend_v = 1'b1;
  endtask

  task automatic idle();
    @(negedge clk);
    compare();
    cmd_valid = 1'b0;
    pend_v    = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_line = '0;
    cmd_req = '0; cmd_perm = '0; cmd_ctx = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    // R12: empty after reset
    for (int s = 0; s < SETS; s++) issue(0, s, 1, 0, 0, 0, "R12");
    issue(4, 0, 1, 0, 0, 0, "R12");
    // R6: fill set 1 in way order
    for (int t = 1; t <= 4; t++) issue(2, 1, t, 0, 0, 0, "R6");
    // R7: duplicate and full-set allocation rejected
    issue(2, 1, 3, 0, 0, 0, "R7");
    issue(2, 1, 9, 0, 0, 0, "R7");
    issue(0, 1, 9, 0, 0, 0, "R7");
    // R9: way 0 is the first victim, then touches reorder
    issue(4, 1, 9, 0, 0, 0, "R9");
    issue(0, 1, 1, 0, 0, 0, "R9");
    issue(4, 1, 9, 0, 0, 0, "R9");
    issue(1, 1, 2, 2, 0, 0, "R9");   // failed store check still touches
    issue(4, 1, 9, 0, 0, 0, "R9");
    // R2: same tag in another set is independent
    issue(0, 2, 1, 0, 0, 0, "R2");
    issue(2, 2, 1, 0, 0, 0, "R2");
    issue(0, 1, 1, 0, 0, 0, "R2");
    // R4 / R11: permissions and request types
    issue(8, 1, 3, 0, 2, 0, "R11");
    issue(1, 1, 3, 0, 0, 0, "R4");
    issue(1, 1, 3, 1, 0, 0, "R4");
    issue(1, 1, 3, 2, 0, 0, "R4");
    issue(1, 1, 4, 0, 0, 0, "R4");
    issue(8, 1, 4, 0, 3, 0, "R11");
    issue(1, 1, 4, 2, 0, 0, "R4");
    issue(0, 1, 4, 0, 0, 0, "R3");
    issue(8, 5, 7, 0, 3, 0, "R11");
    // R10: lock reservations
    issue(7, 1, 3, 0, 0, 15, "R10");
    issue(5, 1, 3, 0, 0, 6, "R10");
    issue(7, 1, 3, 0, 0, 6, "R10");
    issue(7, 1, 3, 0, 0, 5, "R10");
    issue(6, 1, 3, 0, 0, 0, "R10");
    issue(7, 1, 3, 0, 0, 6, "R10");
    issue(5, 1, 12, 0, 0, 2, "R11");
    issue(7, 1, 12, 0, 0, 2, "R11");
    // R8: deallocate and reuse of the lowest free way
    issue(3, 1, 2, 0, 0, 0, "R8");
    issue(3, 1, 2, 0, 0, 0, "R8");
    issue(5, 1, 2, 0, 0, 3, "R8");
    issue(4, 1, 9, 0, 0, 0, "R5");
    issue(2, 1, 9, 0, 0, 0, "R6");
    // R3 / R5: not-present line misses but frees its way
    issue(8, 1, 1, 0, 0, 0, "R3");
    issue(0, 1, 1, 0, 0, 0, "R3");
    issue(4, 1, 10, 0, 0, 0, "R5");
    issue(2, 1, 1, 0, 0, 0, "R6");
    issue(0, 1, 1, 0, 0, 0, "R3");
    idle();
    // Mixed traffic with idle gaps (R1, R9)
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 7) == 0) idle();
      else issue($urandom_range(0, 8), $urandom_range(0, 2), $urandom_range(1, 6),
                 $urandom_range(0, 3), $urandom_range(0, 3),
                 ($urandom_range(0, 3) == 0) ? 15 : $urandom_range(0, 3), "R9");
    end
    idle();
    idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule